// File: doc/BRIEF.md
# Receive Completion Record Batcher

This block sits on the device side of a network receive path. For every received packet it takes one set of completion fields and lays them out as a constant-size 64-byte record. The record holds the packet metadata and the buffer identifier, and every unused byte in it is zero. Records are collected into a small staging store and then written to a host completion ring as one burst. Each burst covers consecutive 64-byte ring slots and carries a single address and a single byte length.

A burst is closed in three cases. The first is that one more record would exceed the maximum write payload. The second is that the burst has reached the last slot of the ring. The third is that no new completion has arrived for a programmable number of cycles.

Both data interfaces are valid/ready.
- On the input stream, a completion is taken on a cycle where `in_valid` and `in_ready` are both high.
- On the output stream, each beat carries one whole record. `wr_addr` and `wr_len` describe the burst and are repeated on every beat of it.
- While a burst is being written, the block accepts no input (`in_ready` is low).
- While `wr_ready` is low, every output is held unchanged, so no completion is lost or reordered.

Top module: `rx_cmpl_batcher`

## Requirements
- R1: Record byte layout, all multi-byte fields little-endian, with byte k on `wr_data[8k+7:8k]`:
  - flags at bytes 0-1
  - buffer id at bytes 2-3
  - segmentation type at byte 4
  - header length at bytes 8-9
  - segment size at bytes 10-11
  - checksum start at bytes 12-13
  - checksum offset at bytes 14-15
  - timestamp at bytes 24-31
- R2: Bytes 5-7, bytes 16-23 and bytes 32-63 of every record are zero.
- R3: Each record is one complete beat of a burst and is never split. `wr_addr` and `wr_len` are constant within a burst, and `wr_len` equals 64 times the number of beats in it.
- R4: A burst never exceeds MAX_PAYLOAD bytes (MAX_PAYLOAD/64 records). When input arrives back to back, a burst is closed as soon as it holds that many records.
- R5: A burst's address is `ring_base` + 64 × slot. Slots start at 0 after reset and advance by the burst's record count, modulo RING_SLOTS.
- R6: A burst never runs past the last ring slot. A burst that reaches the last slot is closed there.
- R7: When the staging store holds records and none is accepted for `idle_limit` consecutive cycles, the burst starts. `wr_valid` is first seen high `idle_limit` cycles after the accepting edge (a value of 0 acts as 1).
- R8: Records leave in the order they were accepted, none lost or repeated. While `wr_valid` is high and `wr_ready` is low, all output signals are held. `in_ready` is low while a burst is pending.
- R9: During reset, `wr_valid` is 0 and `in_ready` is 1.
- R10: `wr_first` is high exactly on the first beat of a burst and `wr_last` exactly on its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of ring slot 0, 64-byte aligned |
| idle_limit | input | IDLE_W | Idle cycles before a partial batch is flushed |
| in_valid | input | 1 | Completion fields valid |
| in_ready | output | 1 | Block can accept a completion |
| in_flags | input | 16 | Completion flags |
| in_buf_id | input | 16 | Buffer identifier |
| in_seg_type | input | 8 | Segmentation type |
| in_hdr_len | input | 16 | Header length |
| in_seg_size | input | 16 | Segment size |
| in_csum_start | input | 16 | Checksum start |
| in_csum_off | input | 16 | Checksum offset |
| in_tstamp | input | 64 | Receive timestamp |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write sink accepts the beat |
| wr_addr | output | ADDR_W | Burst start address |
| wr_len | output | LEN_W | Burst length in bytes |
| wr_first | output | 1 | First beat of burst |
| wr_last | output | 1 | Final beat of burst |
| wr_data | output | 512 | One 64-byte record |

## Verification
The assertions assume the following about the inputs:
- `ring_base` is 64-byte aligned and does not change while records are staged or a burst is pending.
- `idle_limit` only changes while the block is empty.
- The write sink does not rely on `wr_valid` dropping before a handshake.

The bench changes `ring_base` only before reset and changes `idle_limit` only after all expected records have been seen at the output. It drives every input shortly after the rising edge, with random gaps on `in_valid` and random `wr_ready` stalls, so every handshake is well formed.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int REC_BYTES = 64;
  localparam int REC_BITS  = REC_BYTES * 8;
  localparam int REC_SHIFT = $clog2(REC_BYTES);

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] buf_id;
    logic [7:0]  seg_type;
    logic [15:0] hdr_len;
    logic [15:0] seg_size;
    logic [15:0] csum_start;
    logic [15:0] csum_off;
    logic [63:0] tstamp;
  } cmpl_t;

  typedef enum logic {ST_COLLECT, ST_DRAIN} bat_state_t;
endpackage

// File: rtl/rcb_rec_pack.sv
module rcb_rec_pack
  import rcb_pkg::*;
(
  input  cmpl_t               cmpl,
  output logic [REC_BITS-1:0] rec
);
  // Byte k of the record sits at rec[8k+7:8k]; multi-byte fields little-endian.
  always_comb begin
    rec = '0;
    rec[0*8  +: 16] = cmpl.flags;
    rec[2*8  +: 16] = cmpl.buf_id;
    rec[4*8  +: 8]  = cmpl.seg_type;
    rec[8*8  +: 16] = cmpl.hdr_len;
    rec[10*8 +: 16] = cmpl.seg_size;
    rec[12*8 +: 16] = cmpl.csum_start;
    rec[14*8 +: 16] = cmpl.csum_off;
    rec[24*8 +: 64] = cmpl.tstamp;
  end
endmodule

// File: rtl/rcb_rec_store.sv
module rcb_rec_store
  import rcb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [REC_BITS-1:0] wdata,
  input  logic [IDX_W-1:0]    ridx,
  output logic [REC_BITS-1:0] rdata
);
  logic [REC_BITS-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(g))) mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/rcb_ctrl.sv
module rcb_ctrl
  import rcb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDLE_W     = 16,
  parameter int RING_SLOTS = 16,
  parameter int MAX_RECS   = 4,
  localparam int SLOT_W = $clog2(RING_SLOTS),
  localparam int IDX_W  = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1,
  localparam int CNT_W  = $clog2(MAX_RECS + 1),
  localparam int LEN_W  = $clog2(MAX_RECS * REC_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_widx,
  output logic [IDX_W-1:0]  st_ridx,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic              wr_first,
  output logic              wr_last
);
  bat_state_t        state;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  rd_idx;
  logic [SLOT_W-1:0] start_slot;
  logic [IDLE_W-1:0] idle_cnt;

  logic              accept, fire, last_beat, full_hit, ring_hit, idle_hit;
  logic [CNT_W-1:0]  cnt_inc;

  always_comb begin
    in_ready  = (state == ST_COLLECT);
    accept    = in_valid && in_ready;
    wr_valid  = (state == ST_DRAIN);
    fire      = wr_valid && wr_ready;
    cnt_inc   = count + CNT_W'(1);
    full_hit  = (32'(cnt_inc) == 32'(MAX_RECS));
    ring_hit  = (32'(start_slot) + 32'(cnt_inc)) == 32'(RING_SLOTS);
    idle_hit  = ({1'b0, idle_cnt} + (IDLE_W+1)'(1)) >= {1'b0, idle_limit};
    last_beat = (32'(rd_idx) + 32'd1) == 32'(count);
    st_we     = accept;
    st_widx   = IDX_W'(count);
    st_ridx   = rd_idx;
    wr_addr   = ring_base + (ADDR_W'(start_slot) << REC_SHIFT);
    wr_len    = LEN_W'(count) << REC_SHIFT;
    wr_first  = wr_valid && (rd_idx == '0);
    wr_last   = wr_valid && last_beat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_COLLECT;
      count      <= '0;
      rd_idx     <= '0;
      start_slot <= '0;
      idle_cnt   <= '0;
    end else if (state == ST_COLLECT) begin
      if (accept) begin
        count    <= cnt_inc;
        idle_cnt <= '0;
        if (full_hit || ring_hit) state <= ST_DRAIN;
      end else if (count != '0) begin
        if (idle_hit) begin
          state    <= ST_DRAIN;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + IDLE_W'(1);
        end
      end
    end else if (fire) begin
      if (last_beat) begin
        state      <= ST_COLLECT;
        count      <= '0;
        rd_idx     <= '0;
        start_slot <= start_slot + SLOT_W'(count);
      end else begin
        rd_idx <= rd_idx + IDX_W'(1);
      end
    end
  end

  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (count != '0) && (32'(count) <= 32'(MAX_RECS)));

  assert_ring_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (32'(start_slot) + 32'(count)) <= 32'(RING_SLOTS));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_len) && $stable(st_ridx));

  assert_no_intake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  assert_burst_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> !wr_valid && (count == '0));
endmodule

// File: rtl/rx_cmpl_batcher.sv
module rx_cmpl_batcher
  import rcb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDLE_W      = 16,
  parameter int RING_SLOTS  = 16,
  parameter int MAX_PAYLOAD = 256,
  localparam int MAX_RECS = MAX_PAYLOAD / REC_BYTES,
  localparam int IDX_W    = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1,
  localparam int LEN_W    = $clog2(MAX_RECS * REC_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic [IDLE_W-1:0]   idle_limit,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [15:0]         in_flags,
  input  logic [15:0]         in_buf_id,
  input  logic [7:0]          in_seg_type,
  input  logic [15:0]         in_hdr_len,
  input  logic [15:0]         in_seg_size,
  input  logic [15:0]         in_csum_start,
  input  logic [15:0]         in_csum_off,
  input  logic [63:0]         in_tstamp,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [LEN_W-1:0]    wr_len,
  output logic                wr_first,
  output logic                wr_last,
  output logic [REC_BITS-1:0] wr_data
);
  cmpl_t               cmpl;
  logic [REC_BITS-1:0] rec;
  logic                st_we;
  logic [IDX_W-1:0]    st_widx, st_ridx;

  assign cmpl = '{flags: in_flags, buf_id: in_buf_id, seg_type: in_seg_type,
                  hdr_len: in_hdr_len, seg_size: in_seg_size,
                  csum_start: in_csum_start, csum_off: in_csum_off,
                  tstamp: in_tstamp};

  rcb_rec_pack u_pack (.cmpl(cmpl), .rec(rec));

  rcb_rec_store #(.DEPTH(MAX_RECS)) u_store (
    .clk(clk), .we(st_we), .widx(st_widx), .wdata(rec),
    .ridx(st_ridx), .rdata(wr_data)
  );

  rcb_ctrl #(.ADDR_W(ADDR_W), .IDLE_W(IDLE_W), .RING_SLOTS(RING_SLOTS),
             .MAX_RECS(MAX_RECS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .idle_limit(idle_limit),
    .in_valid(in_valid), .in_ready(in_ready),
    .st_we(st_we), .st_widx(st_widx), .st_ridx(st_ridx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_first(wr_first), .wr_last(wr_last)
  );

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[5*8 +: 24] == '0) && (wr_data[16*8 +: 64] == '0)
                 && (wr_data[REC_BITS-1:32*8] == '0));

  assert_len_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_len[REC_SHIFT-1:0] == '0) && (wr_len != '0));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_data) && $stable(wr_first) && $stable(wr_last));
endmodule

// File: tb/tb_rx_cmpl_batcher.sv
module tb_rx_cmpl_batcher;
  localparam int CLK_PERIOD = 10;
  localparam int RING  = 16;
  localparam int MAXP  = 256;
  localparam int MAXR  = MAXP / 64;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] ring_base = BASE;
  logic [15:0] idle_limit = 16'd3;
  logic in_valid = 0, in_ready;
  logic [15:0] in_flags = 0, in_buf_id = 0, in_hdr_len = 0, in_seg_size = 0;
  logic [15:0] in_csum_start = 0, in_csum_off = 0;
  logic [7:0]  in_seg_type = 0;
  logic [63:0] in_tstamp = 0;
  logic wr_valid, wr_ready = 1, wr_first, wr_last;
  logic [31:0] wr_addr;
  logic [8:0]  wr_len;
  logic [511:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_cmpl_batcher #(.RING_SLOTS(RING), .MAX_PAYLOAD(MAXP)) dut (.*);

  int checks = 0, fails = 0;
  logic [511:0] expq [0:1023];
  int wp = 0, rp = 0;
  int exp_slot = 0, beats = 0;
  logic [31:0] b_addr; logic [8:0] b_len;
  bit dir_active = 0; int dir_left = 0, dir_exp = 0;
  bit rdy_rand = 0, stall_seen = 0, done = 0;
  logic [511:0] st_data; logic [31:0] st_addr;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_rec(input logic [15:0] f, id, hl, ss, cs, co,
                                          input logic [7:0] st, input logic [63:0] ts);
    logic [7:0] b [64];
    logic [511:0] r;
    for (int k = 0; k < 64; k++) b[k] = 8'h00;
    b[0] = f[7:0];   b[1] = f[15:8];
    b[2] = id[7:0];  b[3] = id[15:8];
    b[4] = st;
    b[8] = hl[7:0];  b[9] = hl[15:8];
    b[10] = ss[7:0]; b[11] = ss[15:8];
    b[12] = cs[7:0]; b[13] = cs[15:8];
    b[14] = co[7:0]; b[15] = co[15:8];
    for (int k = 0; k < 8; k++) b[24+k] = ts[8*k +: 8];
    for (int k = 0; k < 64; k++) r[8*k +: 8] = b[k];
    return r;
  endfunction

  task automatic send();
    in_flags = 16'($urandom); in_buf_id = 16'($urandom); in_seg_type = 8'($urandom);
    in_hdr_len = 16'($urandom); in_seg_size = 16'($urandom);
    in_csum_start = 16'($urandom); in_csum_off = 16'($urandom);
    in_tstamp = {$urandom, $urandom};
    in_valid = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
    end
    expq[wp] = mk_rec(in_flags, in_buf_id, in_hdr_len, in_seg_size, in_csum_start,
                      in_csum_off, in_seg_type, in_tstamp);
    wp++;
    @(posedge clk); #1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // write-side ready driver
  initial forever begin
    @(posedge clk); #1;
    wr_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
  end

  // output monitor, sampled at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (stall_seen) begin
      chk(wr_valid && wr_data == st_data && wr_addr == st_addr, "R8 hold", wr_data, st_data);
      stall_seen = 0;
    end
    if (wr_valid && !wr_ready) begin
      stall_seen = 1; st_data = wr_data; st_addr = wr_addr;
    end
    if (wr_valid && wr_ready) begin
      chk(wr_first == (beats == 0), "R10 first", 512'(wr_first), 512'(beats == 0));
      if (beats == 0) begin
        b_addr = wr_addr; b_len = wr_len;
        chk(wr_addr == BASE + 32'(exp_slot * 64), "R5 addr", 512'(wr_addr), 512'(BASE + 32'(exp_slot * 64)));
        if (dir_active) begin
          dir_exp = MAXR;
          if (RING - exp_slot < dir_exp) dir_exp = RING - exp_slot;
          if (dir_left < dir_exp) dir_exp = dir_left;
        end
      end
      chk(wr_addr == b_addr && wr_len == b_len, "R3 burst hdr", 512'({wr_addr, wr_len}), 512'({b_addr, b_len}));
      chk(exp_slot + beats < RING, "R6 ring end", 512'(exp_slot + beats), 512'(RING - 1));
      chk(rp < wp && wr_data == expq[rp], "R1 R2 R8 record", wr_data, expq[rp]);
      rp++;
      beats++;
      chk(wr_last == (beats * 64 == int'(wr_len)), "R10 last", 512'(wr_last), 512'(beats * 64 == int'(wr_len)));
      if (wr_last) begin
        chk(beats * 64 == int'(b_len), "R3 len", 512'(b_len), 512'(beats * 64));
        chk(beats <= MAXR, "R4 cap", 512'(beats), 512'(MAXR));
        if (dir_active) begin
          chk(beats == dir_exp, "R4 R6 burst size", 512'(beats), 512'(dir_exp));
          dir_left -= beats;
        end
        exp_slot = (exp_slot + beats) % RING;
        beats = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int n;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_valid == 0 && in_ready == 1, "R9 reset", 512'({wr_valid, in_ready}), 512'(2'b01));
    @(posedge clk); #1; rst_n = 1;

    // R7 idle flush timing with a single record
    idle_limit = 16'd5;
    send(); in_valid = 0;
    n = 0;
    while (n < 50) begin
      @(negedge clk);
      if (wr_valid) break;
      n++;
    end
    chk(n == 5, "R7 idle", 512'(n), 512'(5));
    repeat (4) @(posedge clk); #1;

    // R7 with limit 0 behaves as 1
    idle_limit = 16'd0;
    send(); in_valid = 0;
    n = 0;
    while (n < 50) begin
      @(negedge clk);
      if (wr_valid) break;
      n++;
    end
    chk(n == 1, "R7 idle zero", 512'(n), 512'(1));
    repeat (4) @(posedge clk); #1;

    // random phase: gaps on input, random stalls on output
    idle_limit = 16'd3;
    rdy_rand = 1;
    for (int i = 0; i < 300; i++) begin
      send();
      if ($urandom % 3 == 0) begin
        in_valid = 0;
        repeat ($urandom % 6) @(posedge clk);
        #1;
      end
    end
    in_valid = 0;
    rdy_rand = 0;
    while (rp < wp) @(posedge clk);
    repeat (4) @(posedge clk); #1;

    // directed phase: back-to-back input, bursts sized by cap and ring end
    idle_limit = 16'd8;
    dir_left = 42; dir_active = 1;
    for (int i = 0; i < 42; i++) send();
    in_valid = 0;
    while (rp < wp) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(dir_left == 0, "R4 R6 directed drained", 512'(dir_left), 512'(0));
    report();
  end
endmodule